// File: doc/BRIEF.md
# Reactive State Machine Reaction Controller

The block runs one reactive finite state machine under the control of an external scheduler. Upstream, each input event has a depth-1 buffer that shows a present flag and a data word. The controller waits for a run grant. It then takes one reaction. During that reaction it latches every present flag at once into a snapshot. It reads the data words one cycle later and looks the snapshot up in a fixed transition table. It updates its state and writes its output data. In a separate, later cycle it raises the output events.

If a table entry matches, the controller returns one-cycle consume strobes, but only for the buffers whose events were in the snapshot. If no entry matches, nothing is consumed and nothing changes. A done strobe ends every reaction so that the scheduler can hand the grant to another machine. After reset, the first granted reaction is an unprompted start-up move into the ready state and ignores the inputs.

Top module: `rxn_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it falls, `cur_state` is 0 (BOOT), and `consume`, `out_ev`, `done` and `out_data` are all zero.
- R2: The controller starts a reaction only at a clock edge where `run_grant` is high and either the start-up move is still owed or at least one `in_ev` bit is set. A grant with no stimulus produces no `done`.
- R3: The first reaction after reset moves `cur_state` to 1 (READY). It consumes nothing and emits no events, whatever `in_ev` holds.
- R4: Take edge k as the edge that starts a reaction. `consume` is valid in the cycle after edge k+2. `done` and `out_ev` are valid in the cycle after edge k+3. The four phases idle, detect, execute and emit never overlap.
- R5: The `in_ev` bits are captured together at edge k. `consume` equals that captured set on a match. An event raised after edge k is not consumed by that reaction.
- R6: The data words are sampled at edge k+1, one edge after the flags, so the table uses the values present at edge k+1.
- R7: The state is encoded BOOT=0, READY=1, ARMED=2, FAULT=3, and the output data lanes are `out_data[8*j+7:8*j]`. The table is checked in the order listed below; in each state the first matching row is taken.
  - READY with event 0: go to ARMED and emit output 0 carrying data word 0.
  - READY with event 2: go to FAULT and emit output 1 carrying data word 2.
  - READY with event 1 only: a trivial transition (see R9).
  - ARMED with event 1: go to READY and emit output 1 carrying data word 1.
  - ARMED with event 2: go to FAULT and emit output 1 carrying data word 2.
  - FAULT with events 0 and 1 both present: go to READY and emit both outputs, carrying data words 0 and 1.
- R8: On an empty transition, where no row matches, there is no consume, `cur_state` and `out_data` are unchanged, and no `out_ev` bit is set. `done` still pulses.
- R9: In READY with only event 1 present, the controller consumes event 1, stays in READY and emits nothing.
- R10: An output's data lane changes at edge k+2, and its event appears at edge k+3. The data is therefore steady for a full cycle before and during the event.
- R11: `consume`, `done` and `out_ev` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_grant | input | 1 | Scheduler permission to run a reaction |
| in_ev | input | 3 | Present flags of the input event buffers |
| in_data | input | 24 | Data words of the input buffers, 8 bits each |
| consume | output | 3 | One-cycle clear strobes to the input buffers |
| out_ev | output | 2 | One-cycle output event pulses |
| out_data | output | 16 | Output data words, 8 bits each |
| done | output | 1 | One-cycle end-of-reaction strobe to the scheduler |
| cur_state | output | 2 | Current machine state |

## Verification
The critical overlap is a fresh event arriving on one buffer while a reaction already holds a snapshot that will consume another buffer. The consume strobe for the captured event and the new arrival then fall within the same reaction window. The bench provokes this by raising event 2 in the cycle right after the snapshot edge, while event 1 is being handled. It judges the outcome by requiring that `consume` shows only event 1, and that the next granted reaction finds event 2 still pending and acts on it. A similar overlap is used to check that a data word changed between the flag edge and the data edge reaches the output.

// File: rtl/rxn_pkg.sv
package rxn_pkg;

    parameter int IN_N  = 3;
    parameter int OUT_N = 2;
    parameter int DW    = 8;

    localparam int IN_BITS  = IN_N * DW;
    localparam int OUT_BITS = OUT_N * DW;

    typedef enum logic [1:0] {
        ST_BOOT  = 2'd0,
        ST_READY = 2'd1,
        ST_ARMED = 2'd2,
        ST_FAULT = 2'd3
    } mstate_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_DETECT = 2'd1,
        PH_EXEC   = 2'd2,
        PH_EMIT   = 2'd3
    } phase_e;

    typedef logic [DW-1:0]             word_t;
    typedef logic [IN_N-1:0][DW-1:0]   in_words_t;
    typedef logic [OUT_N-1:0][DW-1:0]  out_words_t;

    typedef struct packed {
        logic                 hit;
        mstate_e              nxt;
        logic [OUT_N-1:0]     oev;
        out_words_t           odat;
    } rel_res_t;

    function automatic rel_res_t rel_none(input mstate_e cur);
        rel_res_t r;
        r.hit  = 1'b0;
        r.nxt  = cur;
        r.oev  = '0;
        r.odat = '0;
        return r;
    endfunction

endpackage

// File: rtl/rxn_phase_seq.sv
module rxn_phase_seq
    import rxn_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   run_grant,
    input  logic   stim,
    input  logic   init_owed,
    output phase_e phase,
    output logic   go
);

    phase_e phase_q;

    assign go    = (phase_q == PH_IDLE) && run_grant && (init_owed || stim);
    assign phase = phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
        end else begin
            unique case (phase_q)
                PH_IDLE:   if (go) phase_q <= PH_DETECT;
                PH_DETECT: phase_q <= PH_EXEC;
                PH_EXEC:   phase_q <= PH_EMIT;
                PH_EMIT:   phase_q <= PH_IDLE;
                default:   phase_q <= PH_IDLE;
            endcase
        end
    end

    // R4: strict phase order, no skipping or overlap
    p_detect_to_exec_r4: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DETECT) |=> (phase_q == PH_EXEC));
    p_exec_to_emit_r4: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_EXEC) |=> (phase_q == PH_EMIT));
    p_emit_to_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_EMIT) |=> (phase_q == PH_IDLE));
    // R2: no grant keeps the sequencer idle
    p_idle_needs_grant_r2: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && !run_grant) |=> (phase_q == PH_IDLE));

endmodule

// File: rtl/rxn_snapshot.sv
module rxn_snapshot
    import rxn_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cap_ev,
    input  logic            cap_data,
    input  logic            blank,
    input  logic [IN_N-1:0] in_ev,
    input  in_words_t       in_words,
    output logic [IN_N-1:0] snap_ev,
    output in_words_t       snap_words
);

    logic [IN_N-1:0] ev_q;
    in_words_t       wd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ev_q <= '0;
        end else if (cap_ev) begin
            ev_q <= blank ? '0 : in_ev;
        end
    end

    for (genvar i = 0; i < IN_N; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                wd_q[i] <= '0;
            end else if (cap_data) begin
                wd_q[i] <= in_words[i];
            end
        end
    end

    assign snap_ev    = ev_q;
    assign snap_words = wd_q;

    // R5: snapshot frozen while no capture is requested
    p_snap_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(cap_ev) |-> $stable(ev_q));

endmodule

// File: rtl/rxn_relation.sv
module rxn_relation
    import rxn_pkg::*;
(
    input  mstate_e         cur,
    input  logic [IN_N-1:0] ev,
    input  in_words_t       wd,
    output rel_res_t        res
);

    always_comb begin
        res = rel_none(cur);
        unique case (cur)
            ST_READY: begin
                if (ev[0]) begin
                    res.hit     = 1'b1;
                    res.nxt     = ST_ARMED;
                    res.oev[0]  = 1'b1;
                    res.odat[0] = wd[0];
                end else if (ev[2]) begin
                    res.hit     = 1'b1;
                    res.nxt     = ST_FAULT;
                    res.oev[1]  = 1'b1;
                    res.odat[1] = wd[2];
                end else if (ev[1]) begin
                    res.hit     = 1'b1;
                    res.nxt     = ST_READY;
                end
            end
            ST_ARMED: begin
                if (ev[1]) begin
                    res.hit     = 1'b1;
                    res.nxt     = ST_READY;
                    res.oev[1]  = 1'b1;
                    res.odat[1] = wd[1];
                end else if (ev[2]) begin
                    res.hit     = 1'b1;
                    res.nxt     = ST_FAULT;
                    res.oev[1]  = 1'b1;
                    res.odat[1] = wd[2];
                end
            end
            ST_FAULT: begin
                if (ev[0] && ev[1]) begin
                    res.hit     = 1'b1;
                    res.nxt     = ST_READY;
                    res.oev     = '1;
                    res.odat[0] = wd[0];
                    res.odat[1] = wd[1];
                end
            end
            default: res = rel_none(cur);
        endcase
    end

endmodule

// File: rtl/rxn_ctrl.sv
module rxn_ctrl
    import rxn_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                run_grant,
    input  logic [IN_N-1:0]     in_ev,
    input  logic [IN_BITS-1:0]  in_data,
    output logic [IN_N-1:0]     consume,
    output logic [OUT_N-1:0]    out_ev,
    output logic [OUT_BITS-1:0] out_data,
    output logic                done,
    output logic [1:0]          cur_state
);

    phase_e          phase;
    logic            go;
    logic            init_owed;
    mstate_e         state_q;
    logic [IN_N-1:0] snap_ev;
    in_words_t       snap_words;
    in_words_t       in_words;
    rel_res_t        rel;
    logic [OUT_N-1:0] emit_q;
    logic [OUT_N-1:0] oev_q;
    out_words_t      odat_q;
    logic [IN_N-1:0] cons_q;
    logic            done_q;

    for (genvar i = 0; i < IN_N; i++) begin : g_unpack
        assign in_words[i] = in_data[i*DW +: DW];
    end

    rxn_phase_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .run_grant (run_grant),
        .stim      (|in_ev),
        .init_owed (init_owed),
        .phase     (phase),
        .go        (go)
    );

    rxn_snapshot u_snap (
        .clk        (clk),
        .rst        (rst),
        .cap_ev     (go),
        .cap_data   (phase == PH_DETECT),
        .blank      (init_owed),
        .in_ev      (in_ev),
        .in_words   (in_words),
        .snap_ev    (snap_ev),
        .snap_words (snap_words)
    );

    rxn_relation u_rel (
        .cur (state_q),
        .ev  (snap_ev),
        .wd  (snap_words),
        .res (rel)
    );

    wire exec_now = (phase == PH_EXEC);
    wire take     = exec_now && !init_owed && rel.hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_BOOT;
            init_owed <= 1'b1;
            emit_q    <= '0;
            cons_q    <= '0;
        end else begin
            cons_q <= '0;
            if (exec_now) begin
                if (init_owed) begin
                    state_q   <= ST_READY;
                    init_owed <= 1'b0;
                    emit_q    <= '0;
                end else if (rel.hit) begin
                    state_q <= rel.nxt;
                    cons_q  <= snap_ev;
                    emit_q  <= rel.oev;
                end else begin
                    emit_q <= '0;
                end
            end
        end
    end

    for (genvar j = 0; j < OUT_N; j++) begin : g_olane
        always_ff @(posedge clk) begin
            if (rst) begin
                odat_q[j] <= '0;
            end else if (take && rel.oev[j]) begin
                odat_q[j] <= rel.odat[j];
            end
        end
        assign out_data[j*DW +: DW] = odat_q[j];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            oev_q  <= '0;
            done_q <= 1'b0;
        end else begin
            oev_q  <= (phase == PH_EMIT) ? emit_q : '0;
            done_q <= (phase == PH_EMIT);
        end
    end

    assign consume   = cons_q;
    assign out_ev    = oev_q;
    assign done      = done_q;
    assign cur_state = state_q;

    // R5: consume strobes only cover captured events
    p_consume_in_snap_r5: assert property (@(posedge clk) disable iff (rst)
        ((consume & ~snap_ev) == '0));
    // R8: an empty transition consumes nothing and holds state
    p_empty_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (exec_now && !init_owed && !rel.hit) |=> (consume == '0 && $stable(state_q) && $stable(out_data)));
    // R3: start-up reaction consumes nothing and lands in READY
    p_init_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (exec_now && init_owed) |=> (consume == '0 && state_q == ST_READY));
    // R10: output events only with done and over steady data
    p_ev_with_done_r10: assert property (@(posedge clk) disable iff (rst)
        (out_ev != '0) |-> (done && $stable(out_data)));
    // R11: single-cycle pulses
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_consume_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        (consume != '0) |=> (consume == '0));

endmodule

// File: tb/sim_rxn_ctrl.sv
module sim_rxn_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_grant = 1'b0;
    logic [2:0]  in_ev = '0;
    logic [23:0] in_data = '0;
    logic [2:0]  consume;
    logic [1:0]  out_ev;
    logic [15:0] out_data;
    logic        done;
    logic [1:0]  cur_state;

    int checks = 0;
    int errors = 0;

    // observations of one reaction
    logic [2:0]  ob_cons_exec, ob_cons, ob_cons_emit;
    logic [1:0]  ob_state, ob_oev_early, ob_oev, ob_oev_after;
    logic [15:0] ob_data;
    logic        ob_done_detect, ob_done, ob_done_after;

    always #4 clk = ~clk;

    rxn_ctrl u0 (
        .clk       (clk),
        .rst       (rst),
        .run_grant (run_grant),
        .in_ev     (in_ev),
        .in_data   (in_data),
        .consume   (consume),
        .out_ev    (out_ev),
        .out_data  (out_data),
        .done      (done),
        .cur_state (cur_state)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // One granted reaction; the bench acts as the input buffers.
    task automatic do_react(input logic [2:0] ev, input logic [23:0] d_k,
                            input logic [23:0] d_late, input logic [2:0] late_ev);
        @(negedge clk);
        in_ev     = ev;
        in_data   = d_k;
        run_grant = 1'b1;
        tick();                 // edge k
        run_grant = 1'b0;
        in_data   = d_late;
        in_ev     = in_ev | late_ev;
        ob_done_detect = done;
        tick();                 // edge k+1
        ob_cons_exec = consume;
        tick();                 // edge k+2
        ob_cons      = consume;
        ob_state     = cur_state;
        ob_data      = out_data;
        ob_oev_early = out_ev;
        in_ev        = in_ev & ~consume;
        tick();                 // edge k+3
        ob_done      = done;
        ob_oev       = out_ev;
        ob_cons_emit = consume;
        tick();                 // edge k+4
        ob_done_after = done;
        ob_oev_after  = out_ev;
    endtask

    task automatic common_timing(input logic [15:0] data_exp);
        chk(ob_done_detect == 1'b0 && ob_cons_exec == 3'b0, "R4 early cycles quiet", {ob_done_detect, ob_cons_exec}, 0);
        chk(ob_oev_early == 2'b0, "R10 data before event", ob_oev_early, 0);
        chk(ob_data == data_exp, "R10 out_data at k+2", ob_data, data_exp);
        chk(ob_done == 1'b1, "R4 done at k+3", ob_done, 1);
        chk(ob_done_after == 1'b0 && ob_oev_after == 2'b0 && ob_cons_emit == 3'b0,
            "R11 single-cycle pulses", {ob_done_after, ob_oev_after, ob_cons_emit}, 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(cur_state == 2'd0 && consume == 0 && out_ev == 0 && done == 0 && out_data == 0,
            "R1 during reset", {cur_state, consume, out_ev, done, out_data}, 0);
        rst = 1'b0;
        tick();
        chk(cur_state == 2'd0 && done == 0 && out_data == 0, "R1 after reset", {cur_state, done, out_data}, 0);
    endtask

    task automatic t_no_grant();
        int seen = 0;
        in_ev = 3'b111;
        for (int i = 0; i < 6; i++) begin
            tick();
            if (done || cur_state != 2'd0) seen++;
        end
        chk(seen == 0, "R2 no grant no reaction", seen, 0);
    endtask

    task automatic t_init();
        do_react(3'b111, 24'h0, 24'h0, 3'b0);
        chk(ob_cons == 3'b0, "R3 init consumes nothing", ob_cons, 0);
        chk(ob_state == 2'd1, "R3 init to READY", ob_state, 1);
        chk(ob_oev == 2'b0, "R3 init emits nothing", ob_oev, 0);
        common_timing(16'h0);
        in_ev = '0;
    endtask

    task automatic t_grant_no_stim();
        int seen = 0;
        @(negedge clk);
        in_ev     = '0;
        run_grant = 1'b1;
        for (int i = 0; i < 6; i++) begin
            tick();
            if (done) seen++;
        end
        run_grant = 1'b0;
        chk(seen == 0, "R2 grant without stimulus", seen, 0);
    endtask

    task automatic t_ready_arm();
        do_react(3'b001, 24'h000011, 24'h00005A, 3'b0);
        chk(ob_cons == 3'b001, "R7 consume event 0", ob_cons, 3'b001);
        chk(ob_state == 2'd2, "R7 READY->ARMED", ob_state, 2);
        chk(ob_oev == 2'b01, "R7 output 0 emitted", ob_oev, 2'b01);
        chk(ob_data == 16'h005A, "R6 data sampled one edge later", ob_data, 16'h005A);
        common_timing(16'h005A);
    endtask

    task automatic t_empty();
        do_react(3'b001, 24'h0000EE, 24'h0000EE, 3'b0);
        chk(ob_cons == 3'b0, "R8 no consume", ob_cons, 0);
        chk(ob_state == 2'd2, "R8 state held", ob_state, 2);
        chk(ob_oev == 2'b0, "R8 no output event", ob_oev, 0);
        common_timing(16'h005A);
        in_ev = '0;
    endtask

    task automatic t_late_arrival();
        do_react(3'b010, 24'h773300, 24'h773300, 3'b100);
        chk(ob_cons == 3'b010, "R5 late event not consumed", ob_cons, 3'b010);
        chk(ob_state == 2'd1, "R7 ARMED->READY", ob_state, 1);
        chk(ob_oev == 2'b10, "R7 output 1 emitted", ob_oev, 2'b10);
        common_timing(16'h335A);
        chk(in_ev == 3'b100, "R5 late event still pending", in_ev, 3'b100);
        do_react(in_ev, 24'h773300, 24'h773300, 3'b0);
        chk(ob_cons == 3'b100 && ob_state == 2'd3, "R5 pending event served", {ob_cons, ob_state}, {3'b100, 2'd3});
        chk(ob_oev == 2'b10, "R7 READY->FAULT output 1", ob_oev, 2'b10);
        common_timing(16'h775A);
    endtask

    task automatic t_fault_exit();
        do_react(3'b011, 24'h00B2A1, 24'h00B2A1, 3'b0);
        chk(ob_cons == 3'b011, "R7 FAULT consumes both", ob_cons, 3'b011);
        chk(ob_state == 2'd1 && ob_oev == 2'b11, "R7 FAULT->READY both outputs", {ob_state, ob_oev}, {2'd1, 2'b11});
        common_timing(16'hB2A1);
    endtask

    task automatic t_trivial();
        do_react(3'b010, 24'h00CC00, 24'h00CC00, 3'b0);
        chk(ob_cons == 3'b010, "R9 trivial consumes", ob_cons, 3'b010);
        chk(ob_state == 2'd1 && ob_oev == 2'b0, "R9 no state change no output", {ob_state, ob_oev}, {2'd1, 2'b0});
        common_timing(16'hB2A1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R4 watchdog expired actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_no_grant();
        t_init();
        t_grant_no_stim();
        t_ready_arm();
        t_empty();
        t_late_arrival();
        t_fault_exit();
        t_trivial();
        repeat (3) tick();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule